// File: doc/BRIEF.md
# Internal Oscillator Frequency Selector

This block forms the clock that an internal oscillator hands to the rest of a chip. A free-running 8-bit counter runs on a fast base oscillator (8 MHz nominal). Its bits give binary fractions of the base rate. A three-bit frequency code picks the output: the base clock itself, one of six counter taps, or the lowest setting near 31 kHz. For the lowest setting, a source bit decides where the clock comes from. When the bit is set, the clock is the base clock divided by 256. When it is clear, the clock is a separate low-power slow oscillator.

When the slow oscillator supplies the lowest setting, the block drops its enable to the fast oscillator so that the fast oscillator can power down. A settle counter reports when the fast oscillator can be trusted again after its enable rises. The slow oscillator is also copied unchanged to a second output for watchdog and clock-monitor logic. That copy does not depend on the configuration.

Configuration arrives through a single-cycle write strobe in the base clock domain. After reset the code selects 1 MHz and the source bit is clear.

Top module: `osc_freq_select`

## Requirements
- R1: While reset is asserted and after it is released, the frequency code is 3'b100 and the source bit is 0. This gives a 1 MHz output (counter bit 2), a high fast enable and a low stable flag.
- R2: Codes 3'b110, 3'b101, 3'b100, 3'b011, 3'b010 and 3'b001 route counter bits 0, 1, 2, 3, 4 and 5 to the output (4 MHz down to 125 kHz). The counter starts at 0 when reset is released and gains 1 on every base clock rising edge.
- R3: Code 3'b111 routes the base clock itself to the output.
- R4: Code 3'b000 with the source bit set routes counter bit 7 (base divided by 256) to the output.
- R5: Code 3'b000 with the source bit clear routes the slow oscillator to the output.
- R6: The fast enable is low exactly when the stored code is 3'b000 and the stored source bit is 0. Otherwise it is high.
- R7: The watchdog clock output always equals the slow oscillator input.
- R8: The stable flag rises on the STABLE_CYCLES-th base edge that samples the fast enable high after a low period or after reset. It clears on the first base edge that samples the enable low.
- R9: A configuration write is stored on the base edge that samples the strobe, and the output follows the new code from that edge. The counter is not restarted by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Fast base oscillator clock (8 MHz nominal) |
| clk_slow | input | 1 | Low-power slow oscillator clock (31 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, sampled on clk_base |
| cfg_freq | input | 3 | Frequency code written when cfg_we is high |
| cfg_src_fast | input | 1 | Lowest-setting source: 1 = divided base clock, 0 = slow oscillator |
| clk_out | output | 1 | Selected output clock |
| slow_out | output | 1 | Slow oscillator copy for watchdog and clock-monitor logic |
| fast_en | output | 1 | Enable to the fast oscillator |
| fast_stable | output | 1 | Fast oscillator has run long enough since its enable rose |

## Verification
The bench steps in whole base clock cycles and samples one time unit after each falling edge. A write driven in the low phase is therefore stored at the next rising edge and is due at the next sample. The R9 check is taken at that first sample, and the divider taps are compared against a counter model advanced on the same edges. The fast enable follows a write one rising edge later. The stable flag is due on the STABLE_CYCLES-th edge with the enable sampled high, so its model counts the same edges and the flag is checked at every sample. The base-clock route and both slow-oscillator routes are combinational, so they are compared with the bench's own clock signals at the same sampling instant. One extra directed sample in the high phase confirms that code 3'b111 follows the base clock.

// File: rtl/osc_sel_pkg.sv
package osc_sel_pkg;

    localparam int FREQ_W = 3;

    typedef logic [FREQ_W-1:0] freq_code_t;

    localparam freq_code_t CODE_LOWEST = 3'b000;
    localparam freq_code_t CODE_TOP    = 3'b111;
    localparam freq_code_t CODE_RESET  = 3'b100;

    // number of codes served by plain counter taps (001..110)
    localparam int TAP_CODES = 6;

    typedef enum logic [1:0] {
        ROUTE_BASE,
        ROUTE_DIV,
        ROUTE_SLOW
    } route_e;

    typedef struct packed {
        freq_code_t freq;
        logic       src_fast;
    } cfg_t;

endpackage

// File: rtl/osc_postscaler.sv
module osc_postscaler #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] taps
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taps = st_q.cnt;

    // R2: the counter advances by one on every edge once out of reset
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)))
        else $error("divider counter did not step by one");

endmodule

// File: rtl/osc_warmup.sv
module osc_warmup #(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic stable
);

    localparam int WARM_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(STABLE_CYCLES);

    typedef struct packed {
        logic [WARM_W-1:0] cnt;
    } warm_state_t;

    warm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en)                    st_d.cnt = '0;
        else if (st_q.cnt != WARM_DONE) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stable = (st_q.cnt == WARM_DONE);

    // R8: a low enable clears the flag on the next edge
    a_r8_stable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !stable)
        else $error("stable flag survived a low enable");

    // R8: the flag only rises after an edge that saw the enable high
    a_r8_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> $past(en))
        else $error("stable flag rose without enable");

endmodule

// File: rtl/osc_out_mux.sv
module osc_out_mux
    import osc_sel_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  cfg_t             cfg,
    input  logic             clk_base,
    input  logic             clk_slow,
    input  logic [CNT_W-1:0] taps,
    output logic             clk_out
);

    localparam int IDX_W = $clog2(CNT_W);

    route_e           route;
    logic [IDX_W-1:0] tap_idx;

    always_comb begin
        route   = ROUTE_DIV;
        tap_idx = '0;
        if (cfg.freq == CODE_TOP) begin
            route = ROUTE_BASE;
        end else if (cfg.freq == CODE_LOWEST) begin
            if (cfg.src_fast) tap_idx = IDX_W'(CNT_W - 1);
            else              route   = ROUTE_SLOW;
        end else begin
            tap_idx = IDX_W'(TAP_CODES - int'(cfg.freq));
        end
    end

    always_comb begin
        unique case (route)
            ROUTE_BASE: clk_out = clk_base;
            ROUTE_SLOW: clk_out = clk_slow;
            default:    clk_out = taps[tap_idx];
        endcase
    end

endmodule

// File: rtl/osc_freq_select.sv
module osc_freq_select
    import osc_sel_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int STABLE_CYCLES = 16
) (
    input  logic       clk_base,
    input  logic       clk_slow,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_freq,
    input  logic       cfg_src_fast,
    output logic       clk_out,
    output logic       slow_out,
    output logic       fast_en,
    output logic       fast_stable
);

    typedef struct packed {
        cfg_t cfg;
    } top_state_t;

    localparam top_state_t RESET_STATE = '{cfg: '{freq: CODE_RESET, src_fast: 1'b0}};

    top_state_t       st_d, st_q;
    logic [CNT_W-1:0] taps;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg.freq     = cfg_freq;
            st_d.cfg.src_fast = cfg_src_fast;
        end
    end

    always_ff @(posedge clk_base or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign fast_en  = !((st_q.cfg.freq == CODE_LOWEST) && !st_q.cfg.src_fast);
    assign slow_out = clk_slow;

    osc_postscaler #(
        .CNT_W(CNT_W)
    ) u_div (
        .clk  (clk_base),
        .rst_n(rst_n),
        .taps (taps)
    );

    osc_warmup #(
        .STABLE_CYCLES(STABLE_CYCLES)
    ) u_warm (
        .clk   (clk_base),
        .rst_n (rst_n),
        .en    (fast_en),
        .stable(fast_stable)
    );

    osc_out_mux #(
        .CNT_W(CNT_W)
    ) u_mux (
        .cfg     (st_q.cfg),
        .clk_base(clk_base),
        .clk_slow(clk_slow),
        .taps    (taps),
        .clk_out (clk_out)
    );

    // R1: the first edge after reset release still holds the 1 MHz default
    a_r1_reset_default: assert property (@(posedge clk_base) disable iff (!rst_n)
        !$past(rst_n) |-> (st_q.cfg.freq == CODE_RESET && !st_q.cfg.src_fast))
        else $error("reset default code lost");

    // R6: writing the slow lowest setting turns the fast oscillator off
    a_r6_write_off: assert property (@(posedge clk_base) disable iff (!rst_n)
        (cfg_we && cfg_freq == CODE_LOWEST && !cfg_src_fast) |=> !fast_en)
        else $error("fast enable stayed high");

    // R6: any other write keeps or turns the fast oscillator on
    a_r6_write_on: assert property (@(posedge clk_base) disable iff (!rst_n)
        (cfg_we && (cfg_freq != CODE_LOWEST || cfg_src_fast)) |=> fast_en)
        else $error("fast enable stayed low");

    // R6: without a write the enable holds its level
    a_r6_enable_holds: assert property (@(posedge clk_base) disable iff (!rst_n)
        (!cfg_we && $past(rst_n)) |=> $stable(fast_en))
        else $error("fast enable moved without a write");

endmodule

// File: tb/osc_freq_select_tb.sv
module osc_freq_select_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW_HALF  = 1290;
    localparam int STABLE_N   = 16;

    logic       clk_base = 1'b0;
    logic       clk_slow = 1'b0;
    logic       rst_n    = 1'b0;
    logic       cfg_we   = 1'b0;
    logic [2:0] cfg_freq = 3'b000;
    logic       cfg_src_fast = 1'b0;
    logic       clk_out, slow_out, fast_en, fast_stable;

    int n_chk  = 0;
    int n_fail = 0;

    osc_freq_select #(
        .CNT_W(8),
        .STABLE_CYCLES(STABLE_N)
    ) dut_i (
        .clk_base    (clk_base),
        .clk_slow    (clk_slow),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_freq    (cfg_freq),
        .cfg_src_fast(cfg_src_fast),
        .clk_out     (clk_out),
        .slow_out    (slow_out),
        .fast_en     (fast_en),
        .fast_stable (fast_stable)
    );

    always #(CLK_PERIOD/2) clk_base = ~clk_base;
    always #(SLOW_HALF)    clk_slow = ~clk_slow;

    // reference model built from the requirements
    logic [7:0] m_cnt  = '0;
    logic [2:0] m_freq = 3'b100;
    logic       m_src  = 1'b0;
    int         m_warm = 0;

    function automatic logic m_en(logic [2:0] f, logic s);
        return !(f == 3'b000 && !s);
    endfunction

    function automatic logic exp_clk(logic [2:0] f, logic s, logic [7:0] c,
                                     logic cb, logic cs);
        if (f == 3'b111) return cb;
        if (f == 3'b000) return s ? c[7] : cs;
        return c[6 - int'(f)];
    endfunction

    always @(posedge clk_base) begin
        if (!rst_n) begin
            m_cnt  <= '0;
            m_freq <= 3'b100;
            m_src  <= 1'b0;
            m_warm <= 0;
        end else begin
            m_cnt  <= m_cnt + 8'd1;
            m_warm <= m_en(m_freq, m_src) ? ((m_warm == STABLE_N) ? STABLE_N : m_warm + 1) : 0;
            if (cfg_we) begin
                m_freq <= cfg_freq;
                m_src  <= cfg_src_fast;
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b (code %03b src %0b cnt %0d)",
                     tag, act, exp, m_freq, m_src, m_cnt);
        end
    endtask

    task automatic check_all(string clk_tag);
        string t;
        if (clk_tag != "")          t = clk_tag;
        else if (m_freq == 3'b111)  t = "R3";
        else if (m_freq == 3'b000)  t = m_src ? "R4" : "R5";
        else                        t = "R2";
        chk(t,    clk_out,     exp_clk(m_freq, m_src, m_cnt, clk_base, clk_slow));
        chk("R6", fast_en,     m_en(m_freq, m_src));
        chk("R8", fast_stable, m_warm == STABLE_N);
        chk("R7", slow_out,    clk_slow);
    endtask

    // advance to the next sampling point (one unit after a falling edge)
    task automatic next_sample();
        @(negedge clk_base);
        #1;
    endtask

    task automatic write_cfg(logic [2:0] f, logic s);
        cfg_we       = 1'b1;
        cfg_freq     = f;
        cfg_src_fast = s;
        next_sample();
        cfg_we = 1'b0;
        check_all("R9");
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) begin
            next_sample();
            check_all("");
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) next_sample();
        chk("R1", clk_out, 1'b0);
        chk("R1", fast_en, 1'b1);
        chk("R1", fast_stable, 1'b0);
        rst_n = 1'b1;
        next_sample();
        check_all("R1");
        run(STABLE_N + 20);

        // directed: every code in turn, free-running divider across writes
        for (int c = 7; c >= 0; c--) begin
            write_cfg(3'(c), 1'b1);
            run(300);
        end

        // directed: code 111 follows the base clock in its high phase
        write_cfg(3'b111, 1'b0);
        @(posedge clk_base);
        #2;
        chk("R3", clk_out, 1'b1);
        next_sample();
        check_all("R3");

        // directed: slow lowest setting, enable off then warm-up again
        write_cfg(3'b000, 1'b0);
        run(3 * SLOW_HALF / CLK_PERIOD);
        write_cfg(3'b000, 1'b1);
        run(STABLE_N + 4);
        write_cfg(3'b000, 1'b0);
        run(2);
        write_cfg(3'b001, 1'b0);
        run(STABLE_N - 3);
        write_cfg(3'b000, 1'b0);
        run(4);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] f;
            logic       s;
            f = ($urandom_range(0, 3) == 0) ? 3'b000 : 3'($urandom_range(0, 7));
            s = 1'($urandom_range(0, 1));
            write_cfg(f, s);
            run($urandom_range(1, STABLE_N + 12));
        end

        summary();
        $finish;
    end

endmodule